// File: doc/BRIEF.md
# Cascadable serial configuration memory

This block is a read-only bit-serial memory that feeds a stored image to a configuration loader one bit per clock. A pointer register selects the bit presented on the data output. It moves forward on every rising clock edge while the block is enabled and has not yet finished. The image is a parameter, so the contents are fixed at elaboration. Bits leave most-significant first within each stored word, and the words go out in ascending order.

Several of these memories can share one clock and one data line. Each device raises its cascade output once its last bit has been clocked out. That output feeds the enable input of the next device, which then takes over the shared line. A single reset/output-enable pin clears the pointer and releases the data line. Its active level is chosen by a parameter.

Top module: `serial_cfg_rom`

## Requirements
- R1: While the reset level is present on `rst_oe`, the pointer returns to bit 0 and `casc_out` is 0 straight away, without waiting for a clock edge. Once reset is released and the block is enabled, the first bit presented is bit 7 (the MSB) of word 0.
- R2: With `RST_ACTIVE_HIGH`=1 the reset level of `rst_oe` is 1. With `RST_ACTIVE_HIGH`=0 the reset level is 0. The opposite level enables the output.
- R3: While `en_in`=1 and the block is not finished, each rising edge advances the pointer by exactly one bit. Word i sits at `IMAGE[i*WORD_W +: WORD_W]`, and the bits of each word are presented from bit WORD_W-1 down to bit 0.
- R4: While `en_in`=0, the pointer holds its value and `data_drv` is 0. When enable returns, the same bit is presented again.
- R5: The block finishes on the rising edge that consumes its last bit (word WORDS-1, bit 0). From then on `casc_out`=1 and `data_drv`=0.
- R6: Once set, `casc_out` stays 1 whatever `en_in` does, until reset is applied.
- R7: `data_drv` is 1 only when `en_in`=1, reset is not applied and the block is not finished.
- R8: In a chain where the `casc_out` of one device drives the `en_in` of the next, the shared line carries the two images back to back with no gap and no repeated bit. At most one device drives at a time.
- R9: Whenever `data_drv`=0, `data_out` is 0, meaning the line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock; the pointer moves on its rising edge |
| rst_oe | input | 1 | Combined reset / output enable; active level set by `RST_ACTIVE_HIGH` |
| en_in | input | 1 | Chip enable, active high; driven by the previous device's `casc_out` in a chain |
| data_out | output | 1 | Current image bit while driving, 0 when released |
| data_drv | output | 1 | High while this device owns the shared data line |
| casc_out | output | 1 | Cascade enable for the next device; high once the image is exhausted |

## Verification
A pointer that skips or repeats a position corrupts the stream in the same cycle. The bench checks every bit of the two chained images against arithmetic expectations, so such a fault is caught at the first wrong bit. A finish flag set one cycle early or late shows up right at the handoff between devices: either a bit is lost, or both devices drive the line at once. A pointer that moves while enable is low shows up as a wrong bit in the first cycle after enable returns.

// File: rtl/scr_pkg.sv
package scr_pkg;

  // Index of the word that holds stream position pos.
  function automatic int unsigned word_of(input int unsigned pos, input int unsigned wbits);
    return pos / wbits;
  endfunction

  // Bit inside that word; MSB leaves first.
  function automatic int unsigned lane_of(input int unsigned pos, input int unsigned wbits);
    return (wbits - 1) - (pos % wbits);
  endfunction

  // Flat position inside the packed image vector.
  function automatic int unsigned flat_of(input int unsigned pos, input int unsigned wbits);
    return word_of(pos, wbits) * wbits + lane_of(pos, wbits);
  endfunction

endpackage

// File: rtl/scr_polarity.sv
module scr_polarity #(
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input  logic pin,
  output logic rst_act,
  output logic oe_act
);
  generate
    if (RST_ACTIVE_HIGH) begin : g_high
      assign rst_act = pin;
    end else begin : g_low
      assign rst_act = ~pin;
    end
  endgenerate

  assign oe_act = ~rst_act;
endmodule

// File: rtl/scr_pointer.sv
module scr_pointer #(
  parameter int unsigned TOTAL = 32,
  localparam int unsigned AW = (TOTAL > 2) ? $clog2(TOTAL) : 1,
  localparam logic [AW-1:0] LAST = AW'(TOTAL - 1)
) (
  input  logic          clk,
  input  logic          rst_act,
  input  logic          step,
  output logic [AW-1:0] ptr,
  output logic          at_last,
  output logic          done
);
  assign at_last = (ptr == LAST);

  always_ff @(posedge clk or posedge rst_act) begin
    if (rst_act) begin
      ptr  <= '0;
      done <= 1'b0;
    end else if (step) begin
      if (at_last) begin
        done <= 1'b1;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  AST_ADVANCE_ONE: assert property (@(posedge clk) disable iff (rst_act)
    step && !at_last |=> ptr == $past(ptr) + 1'b1); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst_act)
    !step |=> $stable(ptr) && $stable(done)); // R4
  AST_FINISH_AT_LAST: assert property (@(posedge clk) disable iff (rst_act)
    step && at_last |=> done); // R5
  AST_FINISH_STICKY: assert property (@(posedge clk) disable iff (rst_act)
    done |=> done); // R6
endmodule

// File: rtl/scr_image.sv
module scr_image
  import scr_pkg::*;
#(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned WORDS  = 4,
  localparam int unsigned TOTAL = WORD_W * WORDS,
  localparam int unsigned AW = (TOTAL > 2) ? $clog2(TOTAL) : 1,
  parameter logic [TOTAL-1:0] IMAGE = '0
) (
  input  logic [AW-1:0] ptr,
  output logic          bit_val
);
  logic [WORD_W-1:0] words [WORDS];

  generate
    for (genvar i = 0; i < WORDS; i++) begin : g_word
      assign words[i] = IMAGE[i*WORD_W +: WORD_W];
    end
  endgenerate

  always_comb begin
    bit_val = 1'b0;
    for (int unsigned p = 0; p < TOTAL; p++) begin
      if (ptr == AW'(p)) begin
        bit_val = words[word_of(p, WORD_W)][lane_of(p, WORD_W)];
      end
    end
  end
endmodule

// File: rtl/scr_out.sv
module scr_out (
  input  logic en,
  input  logic oe_act,
  input  logic done,
  input  logic bit_val,
  output logic drv,
  output logic dout
);
  assign drv  = en & oe_act & ~done;
  assign dout = drv & bit_val;

  always_comb begin
    if (done) begin
      AST_QUIET_WHEN_DONE: assert (!drv); // R5
    end
    if (!oe_act) begin
      AST_QUIET_IN_RESET: assert (!drv); // R7
    end
  end
endmodule

// File: rtl/serial_cfg_rom.sv
module serial_cfg_rom #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned WORDS  = 4,
  parameter bit RST_ACTIVE_HIGH = 1'b1,
  localparam int unsigned TOTAL = WORD_W * WORDS,
  localparam int unsigned AW = (TOTAL > 2) ? $clog2(TOTAL) : 1,
  parameter logic [TOTAL-1:0] IMAGE = '0
) (
  input  logic clk,
  input  logic rst_oe,
  input  logic en_in,
  output logic data_out,
  output logic data_drv,
  output logic casc_out
);
  logic          rst_act;
  logic          oe_act;
  logic          step;
  logic [AW-1:0] ptr;
  logic          at_last;
  logic          done;
  logic          bit_val;

  scr_polarity #(.RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)) u_pol (
    .pin(rst_oe), .rst_act(rst_act), .oe_act(oe_act)
  );

  assign step = en_in & ~done;

  scr_pointer #(.TOTAL(TOTAL)) u_ptr (
    .clk(clk), .rst_act(rst_act), .step(step),
    .ptr(ptr), .at_last(at_last), .done(done)
  );

  scr_image #(.WORD_W(WORD_W), .WORDS(WORDS), .IMAGE(IMAGE)) u_img (
    .ptr(ptr), .bit_val(bit_val)
  );

  scr_out u_out (
    .en(en_in), .oe_act(oe_act), .done(done), .bit_val(bit_val),
    .drv(data_drv), .dout(data_out)
  );

  assign casc_out = done;

  always_comb begin
    if (!data_drv) begin
      AST_RELEASED_LOW: assert (!data_out); // R9
    end
    if (casc_out) begin
      AST_HANDOFF_QUIET: assert (!data_drv); // R8
    end
  end

  AST_CASC_RISE_AT_END: assert property (@(posedge clk) disable iff (rst_act)
    $rose(casc_out) |-> $past(at_last) && $past(en_in)); // R5
endmodule

// File: tb/tb_serial_cfg_rom.sv
module tb_serial_cfg_rom;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int NW = 4;
  localparam int NB = W * NW;

  function automatic logic [W-1:0] word_val(input int seed, input int i);
    return W'((i * 29 + seed * 71 + 5) & 8'hFF);
  endfunction

  function automatic logic [NB-1:0] build(input int seed);
    logic [NB-1:0] v;
    v = '0;
    for (int i = 0; i < NW; i++) v[i*W +: W] = word_val(seed, i);
    return v;
  endfunction

  // Expected bit k of the chained stream (device A first, then B).
  function automatic logic exp_bit(input int k);
    int seed;
    int p;
    seed = (k < NB) ? 1 : 2;
    p = k % NB;
    return word_val(seed, p / W)[W - 1 - (p % W)];
  endfunction

  logic clk = 1'b0;
  logic rst_a, rst_b, en;
  logic a_bit, a_drv, a_casc, b_bit, b_drv, b_casc;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cfg_rom #(.WORD_W(W), .WORDS(NW), .RST_ACTIVE_HIGH(1'b1), .IMAGE(build(1))) dut (
    .clk(clk), .rst_oe(rst_a), .en_in(en),
    .data_out(a_bit), .data_drv(a_drv), .casc_out(a_casc)
  );

  serial_cfg_rom #(.WORD_W(W), .WORDS(NW), .RST_ACTIVE_HIGH(1'b0), .IMAGE(build(2))) dut_b (
    .clk(clk), .rst_oe(rst_b), .en_in(a_casc),
    .data_out(b_bit), .data_drv(b_drv), .casc_out(b_casc)
  );

  wire line = a_bit | b_bit;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic next_cycle();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_a = 1'b1; rst_b = 1'b0; en = 1'b1;
    repeat (3) next_cycle();
    chk("R7 A quiet in reset", a_drv, 0);
    chk("R2 B low-level reset", b_drv, 0);
    chk("R1 casc A clear", a_casc, 0);
    chk("R1 casc B clear", b_casc, 0);
    chk("R9 released low", a_bit, 0);

    en = 1'b0; rst_a = 1'b0; rst_b = 1'b1;
    #1;
    chk("R4 no drive when disabled", a_drv, 0);
    repeat (3) next_cycle();
    en = 1'b1;
    #1;
    chk("R1 first bit MSB of word 0", line, exp_bit(0));
    chk("R2 A drives after release", a_drv, 1);

    for (int k = 0; k < 2 * NB; k++) begin
      chk("R3 R8 stream bit", line, exp_bit(k));
      chk("R8 single owner", a_drv + b_drv, 1);
      chk("R9 idle device low", (a_drv ? b_bit : a_bit), 0);
      if (k == NB) chk("R5 A handed off", {a_casc, a_drv}, 2'b10);
      if (k == 10) begin
        en = 1'b0;
        for (int j = 0; j < 3; j++) begin
          next_cycle();
          chk("R4 released while disabled", a_drv, 0);
        end
        en = 1'b1;
        #1;
        chk("R4 pointer held", line, exp_bit(10));
      end
      next_cycle();
    end

    chk("R5 both finished quiet", {a_drv, b_drv}, 0);
    chk("R5 B casc", b_casc, 1);
    en = 1'b0;
    repeat (4) next_cycle();
    chk("R6 A casc held", a_casc, 1);
    chk("R6 B casc held", b_casc, 1);
    en = 1'b1;

    rst_a = 1'b1;
    #1;
    chk("R1 async clear of casc", a_casc, 0);
    chk("R7 no drive in reset", a_drv, 0);
    chk("R6 B casc kept without its reset", b_casc, 1);
    next_cycle();
    rst_a = 1'b0;
    #1;
    chk("R1 restart at bit 0", {a_drv, line}, {1'b1, exp_bit(0)});
    for (int k = 0; k < 6; k++) begin
      chk("R3 restart stream", line, exp_bit(k));
      next_cycle();
    end
    rst_b = 1'b0;
    #1;
    chk("R2 B reset at low level", b_casc, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule